// File: doc/BRIEF.md
# Serial Nibble ALU

This block performs arithmetic and logic on 4-bit values one bit per clock. It uses a single-bit datapath and a carry flip-flop that carries state from one bit step to the next. A small register file holds the operands. A control word (a start pulse, an operation code and three register selects) starts an operation. The block copies the two source registers into operand shift registers, walks through the bits least significant first, and writes the assembled result into the destination register as the last bit is produced.

The final carry-out is kept in a status flag, which can be read after completion. Registers are filled through a simple load port and observed through a combinational read port, the way a constant-load microinstruction and a bus read would use them. The operation is not pipelined: while a run is in progress the block ignores new start pulses and register loads.

Top module: `serial_alu`

## Requirements
- R1: After reset every register reads 0, and `busy`, `done` and `carryFlag` are all 0.
- R2: When the block is idle, `loadEn` writes `loadData` into register `loadSel`. The new value appears on `rdData` (for `rdSel` = `loadSel`) from the next cycle on.
- R3: A start accepted while idle raises `busy` from the next cycle. Exactly WIDTH clock edges after the accepting edge, the destination register holds the result, `busy` is 0 and `done` is 1 for a single cycle.
- R4: Operation code 0 (add) writes (A+B) mod 16 to the destination and sets `carryFlag` to the carry-out of bit 3.
- R5: Operation code 1 (subtract) writes (A−B) mod 16. `carryFlag` becomes 1 when A ≥ B (no borrow) and 0 otherwise.
- R6: Operation codes 2 (AND) and 3 (OR) write the bitwise result and clear `carryFlag`.
- R7: Operation code 4 (complement) writes the bitwise inverse of A, ignores source B and clears `carryFlag`.
- R8: While busy, a start pulse has no effect: the running result is unchanged and no second `done` follows. A start with a reserved code (5, 6 or 7) is also ignored and leaves `busy` at 0.
- R9: While busy, `loadEn` has no effect on any register.
- R10: The destination may equal either source. The operands are the values the registers held at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches an operation when idle |
| opSel | input | 3 | Operation code (0 add, 1 sub, 2 AND, 3 OR, 4 complement) |
| srcASel | input | SELW | First source register |
| srcBSel | input | SELW | Second source register |
| dstSel | input | SELW | Destination register |
| loadEn | input | 1 | Register load strobe (ignored while busy) |
| loadSel | input | SELW | Register to load |
| loadData | input | WIDTH | Value to load |
| rdSel | input | SELW | Register to read |
| rdData | output | WIDTH | Contents of register `rdSel` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carryFlag | output | 1 | Carry-out / no-borrow status of the last operation |

## Verification
The assertions assume that `start`, `opSel` and the select inputs are sampled only at the accepting edge. They also assume that loads are never issued on the same edge as an accepted start, because that case is left unordered. The stimulus drives every input on the falling edge. It issues loads only between operations, and it sends start pulses during a run only when it deliberately tests that they are ignored. Random operands, register choices and operation codes (including reserved codes) are mixed with directed borrow, equal-operand and destination-equals-source cases.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_NOT = 3'd4
  } aluOp_e;

  typedef struct packed {
    logic capture;
    logic step;
    logic finish;
  } ctrlStrobe_t;

  function automatic logic opIsValid(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic opIsArith(input logic [2:0] code);
    return (code == OP_ADD) || (code == OP_SUB);
  endfunction

endpackage

// File: rtl/serial_alu_bitcell.sv
module serial_alu_bitcell
  import serial_alu_pkg::*;
(
  input  logic [2:0] op,
  input  logic       aBit,
  input  logic       bBit,
  input  logic       carryIn,
  output logic       resBit,
  output logic       carryOut
);

  logic bEff;
  logic sumBit;

  always_comb begin
    bEff     = (op == OP_SUB) ? ~bBit : bBit;
    sumBit   = aBit ^ bEff ^ carryIn;
    carryOut = (aBit & bEff) | (carryIn & (aBit ^ bEff));
    case (op)
      OP_ADD,
      OP_SUB:  resBit = sumBit;
      OP_AND:  resBit = aBit & bBit;
      OP_OR:   resBit = aBit | bBit;
      OP_NOT:  resBit = ~aBit;
      default: resBit = 1'b0;
    endcase
  end

endmodule

// File: rtl/serial_alu_ctrl.sv
module serial_alu_ctrl
  import serial_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  opSel,
  output ctrlStrobe_t stb,
  output logic        busy,
  output logic        done
);

  localparam int CNTW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(WIDTH - 1);

  logic [CNTW-1:0] bitCnt;
  logic            lastStep;

  assign lastStep    = busy && (bitCnt == LAST);
  assign stb.capture = !busy && start && opIsValid(opSel);
  assign stb.step    = busy;
  assign stb.finish  = lastStep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      bitCnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        bitCnt <= '0;
        if (stb.capture) busy <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
        if (lastStep) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3
  AST_CAPTURE_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (busy && !done)); // R3
  AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> (done && !busy)); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !stb.finish) |=> busy); // R8
  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && (opSel > 3'd4)) |=> !busy); // R8
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capture, stb.step})); // R3

endmodule

// File: rtl/serial_alu_dpath.sv
module serial_alu_dpath
  import serial_alu_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int NREG  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [2:0]        opSel,
  input  logic [$clog2(NREG)-1:0] srcASel,
  input  logic [$clog2(NREG)-1:0] srcBSel,
  input  logic [$clog2(NREG)-1:0] dstSel,
  input  logic              loadEn,
  input  logic [$clog2(NREG)-1:0] loadSel,
  input  logic [WIDTH-1:0]  loadData,
  input  logic [$clog2(NREG)-1:0] rdSel,
  output logic [WIDTH-1:0]  rdData,
  output logic              carryFlag
);

  localparam int SELW = $clog2(NREG);

  logic [NREG-1:0][WIDTH-1:0] regFile;
  logic [WIDTH-1:0] opA, opB, resSr, nextRes;
  logic [2:0]       curOp;
  logic [SELW-1:0]  curDst;
  logic             carry, resBit, carryOut;

  serial_alu_bitcell u_cell (
    .op       (curOp),
    .aBit     (opA[0]),
    .bBit     (opB[0]),
    .carryIn  (carry),
    .resBit   (resBit),
    .carryOut (carryOut)
  );

  assign nextRes = {resBit, resSr[WIDTH-1:1]};
  assign rdData  = regFile[rdSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA   <= '0;
      opB   <= '0;
      resSr <= '0;
      curOp <= OP_ADD;
      curDst <= '0;
      carry <= 1'b0;
    end else if (stb.capture) begin
      opA    <= regFile[srcASel];
      opB    <= regFile[srcBSel];
      curOp  <= opSel;
      curDst <= dstSel;
      carry  <= (opSel == OP_SUB);
      resSr  <= '0;
    end else if (stb.step) begin
      opA   <= opA >> 1;
      opB   <= opB >> 1;
      resSr <= nextRes;
      if (opIsArith(curOp)) carry <= carryOut;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regFile   <= '0;
      carryFlag <= 1'b0;
    end else if (stb.finish) begin
      regFile[curDst] <= nextRes;
      carryFlag       <= opIsArith(curOp) ? carryOut : 1'b0;
    end else if (loadEn && !stb.step) begin
      regFile[loadSel] <= loadData;
    end
  end

  AST_REGS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.finish) |=> $stable(regFile)); // R9
  AST_LOGIC_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && !opIsArith(curOp)) |=> !carryFlag); // R6
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finish |=> $stable(carryFlag)); // R4
  AST_SUB_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && opSel == OP_SUB) |=> carry); // R5

endmodule

// File: rtl/serial_alu.sv
module serial_alu
  import serial_alu_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int NREG  = 4,
  localparam int SELW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       opSel,
  input  logic [SELW-1:0]  srcASel,
  input  logic [SELW-1:0]  srcBSel,
  input  logic [SELW-1:0]  dstSel,
  input  logic             loadEn,
  input  logic [SELW-1:0]  loadSel,
  input  logic [WIDTH-1:0] loadData,
  input  logic [SELW-1:0]  rdSel,
  output logic [WIDTH-1:0] rdData,
  output logic             busy,
  output logic             done,
  output logic             carryFlag
);

  ctrlStrobe_t stb;

  serial_alu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .opSel (opSel),
    .stb   (stb),
    .busy  (busy),
    .done  (done)
  );

  serial_alu_dpath #(.WIDTH(WIDTH), .NREG(NREG)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .opSel     (opSel),
    .srcASel   (srcASel),
    .srcBSel   (srcBSel),
    .dstSel    (dstSel),
    .loadEn    (loadEn),
    .loadSel   (loadSel),
    .loadData  (loadData),
    .rdSel     (rdSel),
    .rdData    (rdData),
    .carryFlag (carryFlag)
  );

endmodule

// File: tb/sim_serial_alu.sv
`timescale 1ns/1ps
module sim_serial_alu;

  localparam int W = 4;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN, start, loadEn;
  logic [2:0] opSel;
  logic [1:0] srcASel, srcBSel, dstSel, loadSel, rdSel;
  logic [W-1:0] loadData, rdData;
  logic busy, done, carryFlag;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model [N];

  always #4 clk = ~clk;

  serial_alu #(.WIDTH(W), .NREG(N)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .srcASel(srcASel), .srcBSel(srcBSel), .dstSel(dstSel),
    .loadEn(loadEn), .loadSel(loadSel), .loadData(loadData),
    .rdSel(rdSel), .rdData(rdData), .busy(busy), .done(done),
    .carryFlag(carryFlag)
  );

  function automatic logic [W:0] expOp(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] t;
    case (op)
      3'd0: t = {1'b0, a} + {1'b0, b};
      3'd1: begin t[W-1:0] = a - b; t[W] = (a >= b); end
      3'd2: t = {1'b0, a & b};
      3'd3: t = {1'b0, a | b};
      default: t = {1'b0, ~a};
    endcase
    return t;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [W-1:0] val);
    rdSel = sel;
    #1;
    val = rdData;
  endtask

  task automatic doLoad(input logic [1:0] sel, input logic [W-1:0] val);
    logic [W-1:0] got;
    @(negedge clk);
    loadEn = 1'b1; loadSel = sel; loadData = val;
    @(negedge clk);
    loadEn = 1'b0;
    model[sel] = val;
    readReg(sel, got);
    check(got == val, "R2 load readback", got, val);
  endtask

  task automatic doOp(input logic [2:0] op, input logic [1:0] a, input logic [1:0] b,
                      input logic [1:0] d, input bit intrude, input string req);
    logic [W:0] e;
    logic [W-1:0] got;
    logic [1:0] other;
    e = expOp(op, model[a], model[b]);
    other = d + 2'd1;
    if (other == a || other == b) other = d + 2'd2;
    if (other == a || other == b) other = d + 2'd3;
    @(negedge clk);
    start = 1'b1; opSel = op; srcASel = a; srcBSel = b; dstSel = d;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R3 busy after start", busy, 1);
    if (intrude) begin
      start = 1'b1; opSel = 3'd4; srcASel = other; dstSel = other;
      loadEn = 1'b1; loadSel = other; loadData = ~model[other];
    end
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      start = 1'b0; loadEn = 1'b0;
      if (k < W) check(done == 1'b0, "R3 no early done", done, 0);
    end
    check(done == 1'b1 && busy == 1'b0, "R3 done after WIDTH steps", {done, busy}, 2);
    model[d] = e[W-1:0];
    readReg(d, got);
    check(got == e[W-1:0], req, got, e[W-1:0]);
    check(carryFlag == e[W], {req, " flag"}, carryFlag, e[W]);
    if (intrude) begin
      readReg(other, got);
      check(got == model[other], "R9 load while busy ignored", got, model[other]);
    end
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8 single done, no restart", {done, busy}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] got;
    rstN = 1'b0; start = 1'b0; loadEn = 1'b0; opSel = '0;
    srcASel = '0; srcBSel = '0; dstSel = '0; loadSel = '0; loadData = '0; rdSel = '0;
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 0 && done == 0 && carryFlag == 0, "R1 reset outputs", {busy, done, carryFlag}, 0);
    for (int i = 0; i < N; i++) begin
      readReg(2'(i), got);
      check(got == 0, "R1 reset register", got, 0);
    end
    rstN = 1'b1;

    doLoad(2'd0, 4'd9);
    doLoad(2'd1, 4'd7);
    doOp(3'd0, 2'd0, 2'd1, 2'd2, 0, "R4 add 9+7");
    doOp(3'd1, 2'd1, 2'd0, 2'd3, 0, "R5 sub borrow 7-9");
    doOp(3'd1, 2'd0, 2'd1, 2'd3, 0, "R5 sub 9-7");
    doOp(3'd1, 2'd1, 2'd1, 2'd2, 0, "R5 sub equal");
    doOp(3'd2, 2'd0, 2'd1, 2'd2, 0, "R6 and");
    doOp(3'd3, 2'd0, 2'd1, 2'd2, 0, "R6 or");
    doOp(3'd4, 2'd0, 2'd3, 2'd2, 0, "R7 complement");
    doOp(3'd0, 2'd0, 2'd0, 2'd0, 0, "R10 dst equals source");
    doOp(3'd1, 2'd2, 2'd1, 2'd1, 0, "R10 dst equals srcB");
    doOp(3'd0, 2'd0, 2'd1, 2'd2, 1, "R8 start during run");

    // R8 reserved codes
    for (int c = 5; c < 8; c++) begin
      @(negedge clk);
      start = 1'b1; opSel = 3'(c); srcASel = 2'd0; dstSel = 2'd1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b0, "R8 reserved code ignored", busy, 0);
      readReg(2'd1, got);
      check(got == model[1], "R8 reserved code no write", got, model[1]);
    end

    void'($urandom(32'd4711));
    for (int n = 0; n < 150; n++) begin
      logic [2:0] op;
      string tag;
      if ((n % 10) == 0) doLoad(2'($urandom % N), 4'($urandom));
      op = 3'($urandom % 5);
      case (op)
        3'd0: tag = "R4 random add";
        3'd1: tag = "R5 random sub";
        3'd4: tag = "R7 random complement";
        default: tag = "R6 random logic";
      endcase
      doOp(op, 2'($urandom), 2'($urandom), 2'($urandom), ($urandom % 6) == 0, tag);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule